// File: doc/BRIEF.md
# Shadow-memory store/recall controller

This block pairs a small word-addressed SRAM with a shadow nonvolatile array of the same size. The shadow array is modelled as registers. A host reaches the SRAM through a static-RAM style port: active-low chip enable, output enable and write enable, an address, and a data bus split into input, output and output-enable. The host port is sampled on the block clock. In ready mode the SRAM behaves as ordinary read/write storage. In transfer mode the whole array is copied one word per clock, and the host port is shut out until the copy ends.

A copy starts in one of two ways. The first is a power event: a STORE (SRAM to shadow) runs when `pwr_good` drops, and a RECALL (shadow to SRAM) runs when it rises. The second is a software key: six consecutive read accesses at fixed addresses. The last address chooses STORE or RECALL. Any write, and any read at a wrong address, cancels a partly entered key. A RECALL first zeroes every SRAM word and then loads each word from the shadow array. It never modifies the shadow array.

The controller FSM has five states. OFF (power absent, port inactive) goes to CLEAR when power is good. READY (normal access) goes to STORE on power loss or a store key, and to CLEAR on a recall key. STORE goes to READY at the last word, or to OFF if power is gone. CLEAR goes to LOAD at the last word. LOAD goes to READY at the last word.

Top module: `shadow_nv_ctrl`

## Requirements
- R1: In READY, an access with ce_n=0, we_n=1, oe_n=0 sets dq_oe=1 and puts the SRAM word at `addr` on dq_out. ce_n=1 or oe_n=1 gives dq_oe=0. ce_n=0 with we_n=0 writes dq_in into the word at `addr` on the clock edge.
- R2: After reset, busy=0 and dq_oe=0, and both arrays hold zero. The state is OFF. Raising pwr_good starts a RECALL.
- R3: A read access is a clock in which ce_n is low after being high the previous clock, with we_n high; oe_n may be either level. Read accesses at 0x0E, 0x31, 0x03, 0x3C, 0x2A followed by 0x15 start a STORE. The same five followed by 0x26 start a RECALL. busy rises on the edge that samples the sixth access.
- R4: A write, or a read at an address other than the next expected one, cancels the key. A read at 0x0E restarts the key at its second step. No transfer happens for a cancelled key.
- R5: A STORE copies all 2^AW SRAM words into the shadow array. busy stays high for exactly 2^AW clocks.
- R6: A RECALL zeroes the SRAM and then loads it from the shadow array. busy stays high for exactly 2*2^AW clocks. Afterwards the SRAM equals the shadow array, and the shadow array is unchanged, so repeated recalls give the same data.
- R7: While busy, dq_oe stays 0, host writes are dropped, and key reads are not counted.
- R8: When pwr_good falls in READY, a STORE runs and the state then becomes OFF. In OFF, busy=0 and dq_oe=0.
- R9: If pwr_good falls during a software STORE, that STORE completes with its normal length and the state becomes OFF. No second STORE follows.
- R10: standby is 1 only when ce_n=1 and no transfer runs. It stays 0 during a transfer even with ce_n high.
- R11: A key entered partly before a power loss is discarded. After the power-up RECALL, the final key address alone starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_good | input | 1 | High while supply is valid |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW | Word address |
| dq_in | input | DW | Write data from host |
| dq_out | output | DW | Read data to host |
| dq_oe | output | 1 | High when the block drives the data bus |
| busy | output | 1 | High for the whole of a STORE or RECALL |
| standby | output | 1 | Deselected and no transfer running |

## Verification
The bench cancels keys with an interposed write and with a wrong read address. It also re-enters the first key address in the middle of a key, where a detector that fails to restart at step two would miss a valid key. It drops power in the middle of a software STORE: a controller that re-arms the automatic store would show a second busy window. It also drops power with a half-entered key, where a detector that is not cleared would fire after power-up. The bench attempts writes and reads during a transfer. Leaked writes show up as wrong read-back data, and a leaked output enable shows up as dq_oe. Exact busy lengths expose a RECALL that skips its clear phase or a copy with an off-by-one length.

// File: rtl/nv_ctrl_pkg.sv
package nv_ctrl_pkg;

    typedef enum logic [2:0] {
        NV_OFF   = 3'd0,
        NV_READY = 3'd1,
        NV_STORE = 3'd2,
        NV_CLEAR = 3'd3,
        NV_LOAD  = 3'd4
    } nv_state_e;

    typedef enum logic [1:0] {
        XF_IDLE  = 2'd0,
        XF_STORE = 2'd1,
        XF_CLEAR = 2'd2,
        XF_LOAD  = 2'd3
    } xfer_op_e;

    typedef enum logic [1:0] {
        SQ_NONE   = 2'd0,
        SQ_STORE  = 2'd1,
        SQ_RECALL = 2'd2
    } seq_req_e;

endpackage

// File: rtl/nv_seq_detect.sv
module nv_seq_detect
    import nv_ctrl_pkg::*;
#(
    parameter int AW = 6,
    parameter int PREFIX_LEN = 5,
    parameter logic [PREFIX_LEN*AW-1:0] SEQ_TABLE = '0,
    parameter logic [AW-1:0] KEY_STORE = '0,
    parameter logic [AW-1:0] KEY_RECALL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    output seq_req_e      req
);
    localparam int SW = $clog2(PREFIX_LEN + 1);
    localparam logic [AW-1:0] FIRST_ADDR = SEQ_TABLE[AW-1:0];

    logic [SW-1:0] step_q, step_d;
    logic          ce_q;
    logic [AW-1:0] expect_addr;
    logic          rd_event, wr_seen, at_key;

    // previous chip-enable level, used to find the falling edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ce_q <= 1'b1;
        else        ce_q <= ce_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) step_q <= '0;
        else        step_q <= step_d;
    end

    always_comb begin
        expect_addr = FIRST_ADDR;
        for (int k = 0; k < PREFIX_LEN; k++) begin
            if (step_q == SW'(k)) expect_addr = SEQ_TABLE[k*AW +: AW];
        end
    end

    assign rd_event = enable && ce_q && !ce_n && we_n;
    assign wr_seen  = enable && !ce_n && !we_n;
    assign at_key   = (step_q == SW'(PREFIX_LEN));

    always_comb begin
        req    = SQ_NONE;
        step_d = step_q;
        if (!enable || wr_seen) begin
            step_d = '0;
        end else if (rd_event) begin
            if (at_key && addr == KEY_STORE) begin
                req    = SQ_STORE;
                step_d = '0;
            end else if (at_key && addr == KEY_RECALL) begin
                req    = SQ_RECALL;
                step_d = '0;
            end else if (!at_key && addr == expect_addr) begin
                step_d = step_q + SW'(1);
            end else if (addr == FIRST_ADDR) begin
                step_d = SW'(1);
            end else begin
                step_d = '0;
            end
        end
    end

endmodule

// File: rtl/nv_xfer_fsm.sv
module nv_xfer_fsm
    import nv_ctrl_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_good,
    input  seq_req_e      req,
    output nv_state_e     state,
    output xfer_op_e      xfer_op,
    output logic [AW-1:0] xfer_idx,
    output logic          busy
);
    localparam int DEPTH = 1 << AW;
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    nv_state_e     state_q, state_d;
    logic [AW-1:0] idx_q, idx_d;
    logic          last_word;

    assign last_word = (idx_q == LAST_IDX);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= NV_OFF;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            NV_OFF:   if (pwr_good) state_d = NV_CLEAR;
            NV_READY: begin
                if (!pwr_good)              state_d = NV_STORE;
                else if (req == SQ_STORE)   state_d = NV_STORE;
                else if (req == SQ_RECALL)  state_d = NV_CLEAR;
            end
            NV_STORE: if (last_word) state_d = pwr_good ? NV_READY : NV_OFF;
            NV_CLEAR: if (last_word) state_d = NV_LOAD;
            NV_LOAD:  if (last_word) state_d = NV_READY;
            default:  state_d = NV_OFF;
        endcase
    end

    always_comb begin
        if (state_d != state_q) idx_d = '0;
        else if (busy)          idx_d = idx_q + AW'(1);
        else                    idx_d = '0;
    end

    // outputs
    always_comb begin
        xfer_op = XF_IDLE;
        busy    = 1'b0;
        unique case (state_q)
            NV_OFF, NV_READY: begin
                xfer_op = XF_IDLE;
                busy    = 1'b0;
            end
            NV_STORE: begin
                xfer_op = XF_STORE;
                busy    = 1'b1;
            end
            NV_CLEAR: begin
                xfer_op = XF_CLEAR;
                busy    = 1'b1;
            end
            NV_LOAD: begin
                xfer_op = XF_LOAD;
                busy    = 1'b1;
            end
            default: begin
                xfer_op = XF_IDLE;
                busy    = 1'b0;
            end
        endcase
    end

    assign state    = state_q;
    assign xfer_idx = idx_q;

endmodule

// File: rtl/nv_cell_array.sv
module nv_cell_array
    import nv_ctrl_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    input  xfer_op_e      xfer_op,
    input  logic [AW-1:0] xfer_idx,
    output logic [DW-1:0] host_rdata,
    output logic          shadow_we
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] sram_w   [DEPTH];
    logic [DW-1:0] shadow_w [DEPTH];

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        localparam logic [AW-1:0] WADDR = AW'(w);
        logic [DW-1:0] vol_q;
        logic [DW-1:0] nv_q;
        logic          sel;

        assign sel = (xfer_idx == WADDR);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vol_q <= '0;
                nv_q  <= '0;
            end else begin
                unique case (xfer_op)
                    XF_IDLE:  if (host_we && host_addr == WADDR) vol_q <= host_wdata;
                    XF_STORE: if (sel) nv_q  <= vol_q;
                    XF_CLEAR: if (sel) vol_q <= '0;
                    XF_LOAD:  if (sel) vol_q <= nv_q;
                    default:  ;
                endcase
            end
        end

        assign sram_w[w]   = vol_q;
        assign shadow_w[w] = nv_q;
    end

    assign host_rdata = sram_w[host_addr];
    assign shadow_we  = (xfer_op == XF_STORE);

endmodule

// File: rtl/shadow_nv_ctrl.sv
module shadow_nv_ctrl
    import nv_ctrl_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 8,
    parameter int PREFIX_LEN = 5,
    parameter logic [PREFIX_LEN*AW-1:0] SEQ_TABLE =
        {AW'(42), AW'(60), AW'(3), AW'(49), AW'(14)},
    parameter logic [AW-1:0] KEY_STORE  = AW'(21),
    parameter logic [AW-1:0] KEY_RECALL = AW'(38)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_good,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] dq_in,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe,
    output logic          busy,
    output logic          standby
);
    nv_state_e     state;
    xfer_op_e      xfer_op;
    seq_req_e      seq_req;
    logic [AW-1:0] xfer_idx;
    logic          host_sel, host_we, shadow_we;
    logic [DW-1:0] host_rdata;

    assign host_sel = (state == NV_READY) && !ce_n;
    assign host_we  = host_sel && !we_n;

    nv_seq_detect #(
        .AW(AW), .PREFIX_LEN(PREFIX_LEN), .SEQ_TABLE(SEQ_TABLE),
        .KEY_STORE(KEY_STORE), .KEY_RECALL(KEY_RECALL)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .enable(state == NV_READY),
        .ce_n(ce_n), .we_n(we_n), .addr(addr), .req(seq_req)
    );

    nv_xfer_fsm #(.AW(AW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .req(seq_req),
        .state(state), .xfer_op(xfer_op), .xfer_idx(xfer_idx), .busy(busy)
    );

    nv_cell_array #(.AW(AW), .DW(DW)) u_cells (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(addr),
        .host_wdata(dq_in), .xfer_op(xfer_op), .xfer_idx(xfer_idx),
        .host_rdata(host_rdata), .shadow_we(shadow_we)
    );

    assign dq_oe   = host_sel && we_n && !oe_n;
    assign dq_out  = host_rdata;
    assign standby = ce_n && !busy;

endmodule

// File: rtl/nv_ctrl_checker.sv
module nv_ctrl_checker
    import nv_ctrl_pkg::*;
#(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pwr_good,
    input logic          dq_oe,
    input logic          busy,
    input logic          standby,
    input nv_state_e     state,
    input logic          shadow_we,
    input logic [AW-1:0] xfer_idx
);
    assert_no_drive_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !dq_oe);

    assert_standby_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !standby);

    assert_auto_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == NV_READY && !pwr_good) |=> (state == NV_STORE));

    assert_off_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == NV_OFF) |-> (!busy && !dq_oe));

    assert_shadow_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == NV_CLEAR || state == NV_LOAD) |-> !shadow_we);

    assert_clear_before_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == NV_LOAD && $past(state) != NV_LOAD) |-> ($past(state) == NV_CLEAR));

    assert_store_then_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == NV_STORE && xfer_idx == '1 && !pwr_good) |=> (state == NV_OFF));

endmodule

bind shadow_nv_ctrl nv_ctrl_checker #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .dq_oe(dq_oe),
    .busy(busy), .standby(standby), .state(state),
    .shadow_we(shadow_we), .xfer_idx(xfer_idx)
);

// File: tb/sim_shadow_nv_ctrl.sv
module sim_shadow_nv_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;
    localparam logic [AW-1:0] SEQ_A [5] = '{6'h0E, 6'h31, 6'h03, 6'h3C, 6'h2A};
    localparam logic [AW-1:0] K_STORE  = 6'h15;
    localparam logic [AW-1:0] K_RECALL = 6'h26;
    localparam logic [AW-1:0] POKE_A   = 6'h07;

    logic clk = 0, rst_n = 0, pwr_good = 0;
    logic ce_n = 1, oe_n = 1, we_n = 1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic dq_oe, busy, standby;

    int checks = 0, failures = 0;
    logic [DW-1:0] ref_sram [DEPTH];
    logic [DW-1:0] ref_shadow [DEPTH];
    logic cap_oe;
    logic [DW-1:0] cap_val;

    always #(CLK_PERIOD/2) clk = ~clk;

    shadow_nv_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .ce_n(ce_n), .oe_n(oe_n),
        .we_n(we_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .busy(busy), .standby(standby)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int rd_exp(input logic [DW-1:0] v);
        return 256 + int'(v);
    endfunction

    // one host access: drive at a negedge, capture one clock later, then idle one clock
    task automatic host_op(input logic [AW-1:0] a, input bit wr, input bit oe, input logic [DW-1:0] d);
        ce_n = 0; addr = a; we_n = !wr; oe_n = !oe; dq_in = d;
        @(negedge clk);
        cap_oe = dq_oe; cap_val = dq_out;
        ce_n = 1; we_n = 1; oe_n = 1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        host_op(a, 1, 0, d);
        ref_sram[a] = d;
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input string tag);
        host_op(a, 0, 1, 8'h00);
        chk(cap_oe && cap_val == ref_sram[a], tag, {cap_oe, cap_val}, rd_exp(ref_sram[a]));
    endtask

    task automatic prefix(input int from, input int upto);
        for (int k = from; k < upto; k++) host_op(SEQ_A[k], 0, (k % 2) == 0, 8'h00);
    endtask

    task automatic busy_count(input int drop_at, input bit poke, output int n);
        n = 0;
        while (busy && n < 20000) begin
            if (n == drop_at) pwr_good = 0;
            if (poke) begin
                if (n == 1) begin ce_n = 0; we_n = 0; addr = POKE_A; dq_in = ~ref_sram[POKE_A]; end
                if (n == 3) begin we_n = 1; oe_n = 0; end
                if (n == 4) chk(!dq_oe, "R7 no drive while busy", dq_oe, 0);
                if (n == 5) begin ce_n = 1; oe_n = 1; end
                if (n == 7) chk(!standby, "R10 standby held low while busy", standby, 0);
            end
            n++;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic fire(input logic [AW-1:0] a, input int drop_at, input bit poke, output int n);
        ce_n = 0; addr = a; we_n = 1; oe_n = 1;
        @(negedge clk);
        ce_n = 1;
        busy_count(drop_at, poke, n);
    endtask

    task automatic verify_all(input string tag);
        for (int a = 0; a < DEPTH; a++) rd_chk(AW'(a), tag);
    endtask

    task automatic do_recall(input string tag);
        int n;
        prefix(0, 5);
        fire(K_RECALL, -1, 0, n);
        chk(n == 2*DEPTH, {tag, " recall length"}, n, 2*DEPTH);
        for (int a = 0; a < DEPTH; a++) ref_sram[a] = ref_shadow[a];
    endtask

    task automatic do_store(input string tag);
        int n;
        prefix(0, 5);
        fire(K_STORE, -1, 0, n);
        chk(n == DEPTH, {tag, " store length"}, n, DEPTH);
        for (int a = 0; a < DEPTH; a++) ref_shadow[a] = ref_sram[a];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n;
        int seed_dummy;
        seed_dummy = $urandom(32'h0BAD_5EED);
        for (int a = 0; a < DEPTH; a++) begin ref_sram[a] = '0; ref_shadow[a] = '0; end

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R2: reset state, port inactive while power is absent
        chk(!busy, "R2 busy after reset", busy, 0);
        chk(standby, "R10 standby when idle", standby, 1);
        host_op(6'h01, 0, 1, 8'h00);
        chk(!cap_oe, "R2 no drive in off state", cap_oe, 0);

        // R2: power-up recall
        pwr_good = 1;
        @(negedge clk);
        busy_count(-1, 0, n);
        chk(n == 2*DEPTH, "R2 power-up recall length", n, 2*DEPTH);
        rd_chk(6'h05, "R2 zero after power-up");

        // R1: random traffic against the model
        for (int i = 0; i < 300; i++) begin
            logic [AW-1:0] a;
            a = AW'($urandom);
            if (a == SEQ_A[0]) a = a ^ 6'h01;
            if ($urandom % 2) wr(a, DW'($urandom));
            else rd_chk(a, "R1 random read");
        end
        host_op(6'h02, 0, 0, 8'h00);
        chk(!cap_oe, "R1 internal read keeps bus released", cap_oe, 0);

        // R5 then R6 with two recalls
        do_store("R5");
        for (int a = 0; a < 8; a++) wr(AW'(a), 8'hC0 + DW'(a));
        rd_chk(6'h03, "R1 write after store");
        do_recall("R6 first");
        verify_all("R6 sram matches shadow");
        wr(6'h09, 8'h99);
        do_recall("R6 second");
        rd_chk(6'h09, "R6 shadow unchanged by recall");

        // R4: write inside key cancels it
        wr(6'h11, 8'h5A);
        prefix(0, 3);
        wr(6'h12, 8'h6B);
        prefix(3, 5);
        fire(K_STORE, -1, 0, n);
        chk(n == 0, "R4 write cancels key", n, 0);
        // R4: wrong read address cancels it
        prefix(0, 2);
        host_op(6'h3F, 0, 1, 8'h00);
        prefix(2, 5);
        fire(K_STORE, -1, 0, n);
        chk(n == 0, "R4 wrong read cancels key", n, 0);
        do_recall("R4 no store happened");
        rd_chk(6'h11, "R4 shadow kept old word");
        // R4: first address mid-key restarts at step two
        prefix(0, 2);
        prefix(0, 5);
        fire(K_RECALL, -1, 0, n);
        chk(n == 2*DEPTH, "R4 restart at step two", n, 2*DEPTH);
        // R3: key completed with the recall address only when prefix intact
        host_op(K_RECALL, 0, 1, 8'h00);
        chk(!busy, "R3 lone key address ignored", busy, 0);

        // R7 / R10: lockout during a software store
        wr(POKE_A, 8'h3C);
        prefix(0, 5);
        fire(K_STORE, -1, 1, n);
        chk(n == DEPTH, "R5 store length with pokes", n, DEPTH);
        for (int a = 0; a < DEPTH; a++) ref_shadow[a] = ref_sram[a];
        rd_chk(POKE_A, "R7 write dropped while busy");
        chk(standby, "R10 standby after transfer", standby, 1);

        // R8: power fail in ready
        wr(6'h20, 8'hE1);
        for (int a = 0; a < DEPTH; a++) ref_shadow[a] = ref_sram[a];
        pwr_good = 0;
        @(negedge clk);
        busy_count(-1, 0, n);
        chk(n == DEPTH, "R8 auto store length", n, DEPTH);
        host_op(6'h20, 0, 1, 8'h00);
        chk(!cap_oe && !busy, "R8 off state quiet", {cap_oe, busy}, 0);
        pwr_good = 1;
        @(negedge clk);
        busy_count(-1, 0, n);
        chk(n == 2*DEPTH, "R8 recall on power return", n, 2*DEPTH);
        for (int a = 0; a < DEPTH; a++) ref_sram[a] = ref_shadow[a];
        rd_chk(6'h20, "R8 data survived power cycle");

        // R9: power fail during a software store
        wr(6'h21, 8'h7E);
        prefix(0, 5);
        fire(K_STORE, 3, 0, n);
        chk(n == DEPTH, "R9 store finishes once", n, DEPTH);
        for (int a = 0; a < DEPTH; a++) ref_shadow[a] = ref_sram[a];
        begin
            int seen = 0;
            for (int i = 0; i < DEPTH + 4; i++) begin
                if (busy) seen++;
                @(negedge clk);
            end
            chk(seen == 0, "R9 no second store", seen, 0);
        end
        pwr_good = 1;
        @(negedge clk);
        busy_count(-1, 0, n);
        for (int a = 0; a < DEPTH; a++) ref_sram[a] = ref_shadow[a];
        rd_chk(6'h21, "R9 stored word recalled");

        // R11: partial key discarded across power cycle
        prefix(0, 5);
        pwr_good = 0;
        @(negedge clk);
        busy_count(-1, 0, n);
        pwr_good = 1;
        @(negedge clk);
        busy_count(-1, 0, n);
        chk(n == 2*DEPTH, "R11 power-up recall runs", n, 2*DEPTH);
        fire(K_STORE, -1, 0, n);
        chk(n == 0, "R11 stale key discarded", n, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule